// File: doc/BRIEF.md
# DSI Bridge Register-Write Sequencer

This block plays a fixed, ordered list of bridge register writes into a display link's low-power escape-mode transmitter. Each entry is a 16-bit register address paired with a 32-bit value. The block wraps every entry in a generic long-write packet: a three-byte header, a 6-bit error-correcting byte, a six-byte payload and a 16-bit checksum. It works out the error-correcting byte and the checksum itself, one entry at a time.

The list is split into two bursts. A single escape-entry request opens each burst, and a programmable number of clock cycles separates the two bursts. The first burst configures the bridge and the second starts its link layers. Every item goes to the transmitter over a valid/ready handshake. `tx_esc` marks the transfer that asks for a new escape entry, and the other transfers carry one packet byte on `tx_data`. Software pulses `start` after the power-up writes that go over a separate bus. `done` then reports that the whole list has gone out.

The controller has seven states. `S_IDLE` waits for `start`. `S_ESC` offers the escape request. `S_HDR` sends the four header bytes. `S_PAY` sends the six payload bytes. `S_CRC` sends the two checksum bytes. `S_WAIT` runs the inter-burst timer. `S_DONE` holds completion. The transitions are as follows:
- **start-accept:** `S_IDLE` or `S_DONE` to `S_ESC` when `start` is high.
- **escape-taken:** `S_ESC` to `S_HDR` when the escape transfer completes.
- **header-done:** `S_HDR` to `S_PAY` after the fourth header byte.
- **payload-done:** `S_PAY` to `S_CRC` after the sixth payload byte.
- **next-entry:** `S_CRC` to `S_HDR` when the packet was not the last of its burst.
- **burst-break:** `S_CRC` to `S_WAIT` after the last packet of the first burst.
- **list-end:** `S_CRC` to `S_DONE` after the last packet of the list.
- **timer-expired:** `S_WAIT` to `S_ESC` when the timer runs out.

Top module: `dsi_regwrite_seq`

## Requirements
- R1: After reset, `tx_valid` and `done` are low, and they stay low until `start` is seen.
- R2: Each burst opens with exactly one transfer that has `tx_esc`=1. This is the only point at which `tx_valid` rises from low. Packet bytes carry `tx_esc`=0.
- R3: Every packet begins with the bytes 0x29 (the long-write data type), 0x06 and 0x00. The last two are a word count of 6, low byte first.
- R4: The fourth header byte is a 6-bit Hamming-style code over the 24 header bits, with the data type in bits 7:0 and the word count in bits 23:8. Bits 7:6 of that byte are zero. For the header 29 06 00 the code is 0x23.
- R5: The six payload bytes are the register address, low byte first, followed by the 32-bit value, low byte first. For example, address 0x0210 with value 3 gives 10 02 03 00 00 00.
- R6: Two checksum bytes follow the payload, low byte first. The checksum is CRC-16 with polynomial x^16+x^12+x^5+1 and seed 0xFFFF, processed least significant bit first over the payload. For the payload 10 02 03 00 00 00 it gives 85 79.
- R7: The list goes out in a fixed order. The first burst carries 13 writes: 0x0210=3, 0x0164=5, 0x0168=5, 0x0144=0, 0x0148=0, 0x0114=3, 0x0450=0, 0x0424=0x002C0002, 0x042C=0x00150002, 0x0428=0x003D0320 (800 active pixels), 0x0430=0x000701E0 (480 active lines), 0x0420=0x00100152 and 0x0464=0x0000040F. The second burst carries two writes: 0x0104=1, then 0x0204=1.
- R8: After the last checksum byte of the first burst is accepted, `tx_valid` stays low for exactly `WAIT_CYCLES` cycles. The second burst's escape request then appears.
- R9: While `tx_valid` is high and `tx_ready` is low, the offered item holds: `tx_valid`, `tx_esc` and `tx_data` stay unchanged.
- R10: `done` rises in the cycle after the final checksum byte is accepted. It stays high until a new `start`, which replays the whole list from the first burst.
- R11: A `start` pulse while the list is being sent has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or replay) the register-write list |
| tx_ready | input | 1 | Transmitter accepts the offered item this cycle |
| tx_valid | output | 1 | An item is offered to the transmitter |
| tx_esc | output | 1 | Offered item is an escape-entry request, not a byte |
| tx_data | output | 8 | Offered packet byte |
| done | output | 1 | Whole list has been sent |

## Verification
A wrong byte position or entry index shows up in the very next accepted transfer. It appears as a misplaced header byte, a payload byte from the wrong entry or an escape request at the wrong point. A corrupted checksum register only shows in the two checksum bytes that close the same packet, at most eight transfers later. A timer or burst-split fault shows as a gap of the wrong length, or as a missing or extra escape request, when the first burst ends. A state-machine fault after the final write shows as `done` failing to rise, or failing to stay high, in the next cycle.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] value;
    } reg_write_t;

    localparam int REG_COUNT   = 15;
    localparam int FIRST_BURST = 13;
    localparam logic [7:0]  LONG_WRITE_DT = 8'h29;
    localparam logic [15:0] PAYLOAD_WC    = 16'd6;

    typedef enum logic [2:0] {
        S_IDLE, S_ESC, S_HDR, S_PAY, S_CRC, S_WAIT, S_DONE
    } seq_state_t;

    function automatic reg_write_t list_entry(input logic [3:0] i);
        reg_write_t e;
        unique case (i)
            4'd0:    e = '{16'h0210, 32'h0000_0003};
            4'd1:    e = '{16'h0164, 32'h0000_0005};
            4'd2:    e = '{16'h0168, 32'h0000_0005};
            4'd3:    e = '{16'h0144, 32'h0000_0000};
            4'd4:    e = '{16'h0148, 32'h0000_0000};
            4'd5:    e = '{16'h0114, 32'h0000_0003};
            4'd6:    e = '{16'h0450, 32'h0000_0000};
            4'd7:    e = '{16'h0424, 32'h002C_0002};
            4'd8:    e = '{16'h042C, 32'h0015_0002};
            4'd9:    e = '{16'h0428, 32'h003D_0320};
            4'd10:   e = '{16'h0430, 32'h0007_01E0};
            4'd11:   e = '{16'h0420, 32'h0010_0152};
            4'd12:   e = '{16'h0464, 32'h0000_040F};
            4'd13:   e = '{16'h0104, 32'h0000_0001};
            4'd14:   e = '{16'h0204, 32'h0000_0001};
            default: e = '{16'h0000, 32'h0000_0000};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc (
    input  logic [7:0]  data_type,
    input  logic [15:0] word_count,
    output logic [7:0]  ecc
);
    logic [23:0] d;
    assign d = {word_count, data_type};

    always_comb begin
        ecc[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        ecc[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        ecc[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        ecc[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        ecc[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        ecc[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        ecc[7:6] = 2'b00;
    end
endmodule

// File: rtl/dsi_crc16_step.sv
module dsi_crc16_step #(
    parameter logic [15:0] POLY_REFL = 16'h8408
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    logic [15:0] c;
    logic        fb;

    always_comb begin
        c  = crc_in;
        fb = 1'b0;
        for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ data[b];
            c  = {1'b0, c[15:1]};
            if (fb) c = c ^ POLY_REFL;
        end
        crc_out = c;
    end
endmodule

// File: rtl/dsi_wait_timer.sv
module dsi_wait_timer #(
    parameter int WAIT_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= LOAD_VAL;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    assert_timer_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt != '0) |=> (run && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dsi_regwrite_seq.sv
module dsi_regwrite_seq
    import dsi_seq_pkg::*;
#(
    parameter int WAIT_CYCLES = 12_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic       tx_esc,
    output logic [7:0] tx_data,
    output logic       done
);
    localparam int IDX_W = $clog2(REG_COUNT);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(REG_COUNT - 1);
    localparam logic [IDX_W-1:0] BREAK_IDX = IDX_W'(FIRST_BURST - 1);

    seq_state_t       state, next_state;
    logic [IDX_W-1:0] idx;
    logic [2:0]       pos;
    logic [15:0]      crc, crc_next;
    logic [7:0]       ecc_byte;
    logic             fire, timer_load, timer_done;
    reg_write_t       entry;
    logic [47:0]      payload;

    assign fire    = tx_valid && tx_ready;
    assign entry   = list_entry(4'(idx));
    assign payload = {entry.value, entry.addr};

    dsi_hdr_ecc u_ecc (
        .data_type (LONG_WRITE_DT),
        .word_count(PAYLOAD_WC),
        .ecc       (ecc_byte)
    );

    dsi_crc16_step u_crc (
        .crc_in (crc),
        .data   (tx_data),
        .crc_out(crc_next)
    );

    dsi_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .expired(timer_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        timer_load = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: if (start) next_state = S_ESC;
            S_ESC:          if (fire) next_state = S_HDR;
            S_HDR:          if (fire && pos == 3'd3) next_state = S_PAY;
            S_PAY:          if (fire && pos == 3'd5) next_state = S_CRC;
            S_CRC: begin
                if (fire && pos == 3'd1) begin
                    if (idx == LAST_IDX) begin
                        next_state = S_DONE;
                    end else if (idx == BREAK_IDX) begin
                        next_state = S_WAIT;
                        timer_load = 1'b1;
                    end else begin
                        next_state = S_HDR;
                    end
                end
            end
            S_WAIT:         if (timer_done) next_state = S_ESC;
            default:        next_state = S_IDLE;
        endcase
    end

    // datapath: entry index, byte position, running checksum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            pos <= '0;
            crc <= 16'hFFFF;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: if (start) idx <= '0;
                S_ESC:  pos <= '0;
                S_HDR: if (fire) begin
                    crc <= 16'hFFFF;
                    pos <= (pos == 3'd3) ? 3'd0 : pos + 3'd1;
                end
                S_PAY: if (fire) begin
                    crc <= crc_next;
                    pos <= (pos == 3'd5) ? 3'd0 : pos + 3'd1;
                end
                S_CRC: if (fire) begin
                    if (pos == 3'd1) begin
                        pos <= 3'd0;
                        if (idx != LAST_IDX) idx <= idx + 1'b1;
                    end else begin
                        pos <= pos + 3'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_esc   = 1'b0;
        tx_data  = 8'h00;
        done     = 1'b0;
        unique case (state)
            S_ESC: begin
                tx_valid = 1'b1;
                tx_esc   = 1'b1;
            end
            S_HDR: begin
                tx_valid = 1'b1;
                unique case (pos)
                    3'd0:    tx_data = LONG_WRITE_DT;
                    3'd1:    tx_data = PAYLOAD_WC[7:0];
                    3'd2:    tx_data = PAYLOAD_WC[15:8];
                    default: tx_data = ecc_byte;
                endcase
            end
            S_PAY: begin
                tx_valid = 1'b1;
                tx_data  = payload[8*pos +: 8];
            end
            S_CRC: begin
                tx_valid = 1'b1;
                tx_data  = (pos == 3'd0) ? crc[7:0] : crc[15:8];
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_esc) && $stable(tx_data)));

    assert_rise_is_escape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_esc);

    assert_escape_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_esc |-> (idx == '0 || idx == IDX_W'(FIRST_BURST)));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: tb/dsi_regwrite_seq_test.sv
module dsi_regwrite_seq_test;
    localparam int WAITC = 40;
    localparam int SPLIT = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tx_ready = 1'b0;
    logic tx_valid, tx_esc, done;
    logic [7:0] tx_data;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dsi_regwrite_seq #(.WAIT_CYCLES(WAITC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_esc(tx_esc), .tx_data(tx_data), .done(done)
    );

    // expected stream: {esc, byte}, requirement tag, end-of-first-burst marker
    logic [8:0] q_item[$];
    string      q_req[$];
    bit         q_brk[$];

    logic [15:0] e_addr[15] = '{16'h0210, 16'h0164, 16'h0168, 16'h0144, 16'h0148,
                                16'h0114, 16'h0450, 16'h0424, 16'h042C, 16'h0428,
                                16'h0430, 16'h0420, 16'h0464, 16'h0104, 16'h0204};
    logic [31:0] e_val[15] = '{32'd3, 32'd5, 32'd5, 32'd0, 32'd0, 32'd3, 32'd0,
                               32'h002C0002, 32'h00150002, 32'h003D0320,
                               32'h000701E0, 32'h00100152, 32'h0000040F, 32'd1, 32'd1};
    logic [23:0] ecc_mask[6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D,
                                 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_ecc(input logic [23:0] h);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 6; i++) r[i] = ^(h & ecc_mask[i]);
        return r;
    endfunction

    function automatic logic [15:0] model_crc(input logic [47:0] p);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ p[i]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic push(input logic [8:0] it, input string req, input bit brk);
        q_item.push_back(it);
        q_req.push_back(req);
        q_brk.push_back(brk);
    endtask

    task automatic fill_model();
        logic [47:0] pl;
        logic [15:0] c;
        for (int e = 0; e < 15; e++) begin
            if (e == 0 || e == SPLIT) push({1'b1, 8'h00}, "R2", 1'b0);
            push({1'b0, 8'h29}, "R3", 1'b0);
            push({1'b0, 8'h06}, "R3", 1'b0);
            push({1'b0, 8'h00}, "R3", 1'b0);
            push({1'b0, model_ecc(24'h000629)}, "R4", 1'b0);
            pl = {e_val[e], e_addr[e]};
            for (int b = 0; b < 6; b++) push({1'b0, pl[8*b +: 8]}, "R5_R7", 1'b0);
            c = model_crc(pl);
            push({1'b0, c[7:0]}, "R6", 1'b0);
            push({1'b0, c[15:8]}, "R6", e == SPLIT - 1);
        end
    endtask

    initial begin : main
        int cyc = 0;
        int wait_left = 0;
        int gap = 0;
        int sent = 0;
        bit prev_stall = 1'b0;
        logic [8:0] prev_item = '0;
        logic [15:0] lfsr = 16'hACE1;
        bit watchdog = 1'b0;

        // R4 and R6 reference examples inside the model itself
        chk(model_ecc(24'h000629) == 8'h23, "R4", model_ecc(24'h000629), 8'h23);
        chk(model_crc({32'd3, 16'h0210}) == 16'h7985, "R6", model_crc({32'd3, 16'h0210}), 16'h7985);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet without start
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R1", tx_valid, 0);
            chk(done == 1'b0, "R1", done, 0);
        end

        for (int run = 0; run < 2 && !watchdog; run++) begin
            int tail = 0;
            start = 1'b1;
            fill_model();
            sent = 0;
            while (tail < 5) begin
                @(negedge clk);
                start = 1'b0;
                cyc++;
                if (cyc > 20000) begin
                    watchdog = 1'b1;
                    chk(1'b0, "watchdog", cyc, 20000);
                    break;
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tx_ready = (run == 0) ? (lfsr[0] | lfsr[3]) : 1'b1;

                if (prev_stall) begin
                    chk(tx_valid && {tx_esc, tx_data} == prev_item, "R9", {tx_valid, tx_esc, tx_data}, {1'b1, prev_item});
                end
                prev_stall = tx_valid && !tx_ready;
                prev_item = {tx_esc, tx_data};

                if (wait_left > 0) begin
                    chk(tx_valid == 1'b0, "R8", tx_valid, 0);
                    chk(done == 1'b0, "R10", done, 0);
                    wait_left--;
                    gap++;
                    if (wait_left == 0) chk(gap == WAITC, "R8", gap, WAITC);
                end else if (q_item.size() > 0) begin
                    chk(tx_valid == 1'b1, "R2", tx_valid, 1);
                    chk(done == 1'b0, "R10", done, 0);
                    if (tx_valid && tx_ready) begin
                        chk({tx_esc, tx_data} == q_item[0], q_req[0], {tx_esc, tx_data}, q_item[0]);
                        if (q_brk[0]) begin
                            wait_left = WAITC;
                            gap = 0;
                        end
                        void'(q_item.pop_front());
                        void'(q_req.pop_front());
                        void'(q_brk.pop_front());
                        sent++;
                        // R11: start pulse in the middle of a run
                        if (sent == 50) start = 1'b1;
                    end
                end else begin
                    chk(tx_valid == 1'b0, "R10", tx_valid, 0);
                    chk(done == 1'b1, "R10", done, 1);
                    tail++;
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule